// File: doc/BRIEF.md
# Posted DAC Update Controller

This block holds the sample codes for two DAC channels. It decides when each code reaches the converter. In posted mode, a host write only loads a per-channel holding register. Both output registers then copy their holding registers together, on a single update event. That event comes from one source, chosen by configuration: a counter pulse, an external active-low trigger pin, or a software strobe. Because the output moves only on that event, the delay in host servicing does not turn into jitter on the waveform.

Each update raises a request flag that asks the host for the next sample. The host can service the flag by polling, by interrupt or by DMA, and any buffer write clears it. An update that finds no fresh data since the previous update reloads the old codes and sets a sticky underrun flag. Besides the local write port, two other data paths can feed the buffers: a serial path into channel 0 and a FIFO path into channel 1. Only one of these two can be enabled at a time. In direct mode, posting is off, writes reach the outputs on the next clock and no request is raised.

Top module: `dac_post_ctrl`

## Requirements
- R1: After reset, dac0_o and dac1_o are zero, req_o and underrun_o are low, posted mode is off, and the trigger select holds 7 (disabled).
- R2: In posted mode, a buffer write does not change either output. On the clock edge where the selected update event is present, each output takes its holding register's contents from before that edge.
- R3: Trigger select codes 0, 1, 2 and 3 choose ctr_pulse_i bits 0, 1, 2 and 3 (counters 1, 2, 3 and 5), each sampled at the edge where it is high. Codes 6 and 7 disable updates. Pulses on unselected sources have no effect.
- R4: Select code 4 chooses ext_trig_ni, which is active low. A high-to-low change of the pin that is first sampled at rising edge k updates the outputs at edge k+2. Holding the pin low gives exactly one update.
- R5: Select code 5 chooses sw_trig_i, which updates the outputs at the edge where it is high.
- R6: In posted mode, req_o rises on the update edge. The next buffer write clears it. If a write and an update fall on the same edge, req_o stays high, the output takes the old buffer and the buffer takes the new value.
- R7: In direct mode (posted off), a write to a channel appears on its output at the next edge. req_o stays low, and update events have no effect.
- R8: In posted mode, an update with no buffer write since the previous update reloads the same codes and sets underrun_o. underrun_o stays high until a configuration write clears it; a new underrun on that same edge wins over the clear.
- R9: Path select 1 lets ser_valid_i load channel 0 and ignores fifo_valid_i. Path select 2 lets fifo_valid_i load channel 1 and ignores ser_valid_i. Path selects 0 and 3 ignore both paths.
- R10: When a local write and an enabled path target the same channel on the same edge, the local write's data is stored. Path data, like local data, reaches the output in posted mode only on an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_posted_i | input | 1 | Posted mode enable |
| cfg_trig_sel_i | input | 3 | Update source select |
| cfg_path_i | input | 2 | Alternate data path select |
| wr_en_i | input | 1 | Local host write strobe |
| wr_ch_i | input | 1 | Local write channel |
| wr_data_i | input | DATA_W | Local write data |
| ser_valid_i | input | 1 | Serial path word valid (channel 0) |
| ser_data_i | input | DATA_W | Serial path data |
| fifo_valid_i | input | 1 | FIFO path word valid (channel 1) |
| fifo_data_i | input | DATA_W | FIFO path data |
| ctr_pulse_i | input | 4 | Counter pulses for counters 1, 2, 3, 5 |
| ext_trig_ni | input | 1 | External update trigger, active low, asynchronous |
| sw_trig_i | input | 1 | Software update strobe |
| dac0_o | output | DATA_W | Channel 0 output code |
| dac1_o | output | DATA_W | Channel 1 output code |
| req_o | output | 1 | Next-sample request status bit |
| underrun_o | output | 1 | Sticky underrun status bit |

## Verification
A holding register that is corrupt or loaded from the wrong place stays hidden until the next update. It then shows on a DAC output at that exact edge, so each update edge in the bench is also a check of the buffers. A wrong freshness bit shows as a wrong underrun_o on the first update after it goes wrong. A wrong synchronizer depth or edge detector moves the external-trigger update away from the expected edge, or repeats it while the pin stays low. Comparing every output on every cycle against a bench reference model catches each of these within one cycle of the edge that exposes it.

// File: rtl/dac_post_pkg.sv
package dac_post_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_CTR = 4;

  typedef enum logic [2:0] {
    TRG_C1   = 3'd0,
    TRG_C2   = 3'd1,
    TRG_C3   = 3'd2,
    TRG_C5   = 3'd3,
    TRG_EXT  = 3'd4,
    TRG_SW   = 3'd5,
    TRG_OFF6 = 3'd6,
    TRG_OFF7 = 3'd7
  } trig_sel_e;

  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_SER0  = 2'd1,
    PATH_FIFO1 = 2'd2,
    PATH_BLOCK = 2'd3
  } path_sel_e;

  typedef struct packed {
    logic      posted;
    trig_sel_e sel;
    path_sel_e path;
  } dac_cfg_t;
endpackage

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
  import dac_post_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  trig_sel_e          sel_i,
  input  logic [NUM_CTR-1:0] ctr_pulse_i,
  input  logic               ext_trig_ni,
  input  logic               sw_trig_i,
  output logic               upd_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   ext_fall;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sync_q[g] <= 1'b1;
      else if (g == 0) sync_q[g] <= ext_trig_ni;
      else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[LAST];
  end

  assign ext_fall = prev_q & ~sync_q[LAST];

  always_comb begin
    unique case (sel_i)
      TRG_C1:  upd_o = ctr_pulse_i[0];
      TRG_C2:  upd_o = ctr_pulse_i[1];
      TRG_C3:  upd_o = ctr_pulse_i[2];
      TRG_C5:  upd_o = ctr_pulse_i[3];
      TRG_EXT: upd_o = ext_fall;
      TRG_SW:  upd_o = sw_trig_i;
      default: upd_o = 1'b0;
    endcase
  end

  // R4
  ext_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall |=> !ext_fall);

  // R4
  ext_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall |-> $past(sync_q[LAST]) && !sync_q[LAST]);
endmodule

// File: rtl/dac_chan_buf.sv
module dac_chan_buf #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              posted_i,
  input  logic              upd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_o
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (wr_i) hold_q <= data_i;
      if (posted_i) begin
        if (upd_i) out_q <= hold_q;   // copy happens before same-edge write lands
      end else if (wr_i) begin
        out_q <= data_i;
      end
    end
  end

  assign out_o = out_q;

  // R2
  posted_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (posted_i && !upd_i) |=> $stable(out_o));

  // R7
  direct_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!posted_i && wr_i) |=> out_o == $past(data_i));
endmodule

// File: rtl/dac_post_ctrl.sv
module dac_post_ctrl
  import dac_post_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_posted_i,
  input  logic [2:0]         cfg_trig_sel_i,
  input  logic [1:0]         cfg_path_i,
  input  logic               wr_en_i,
  input  logic               wr_ch_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               ser_valid_i,
  input  logic [DATA_W-1:0]  ser_data_i,
  input  logic               fifo_valid_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  input  logic [NUM_CTR-1:0] ctr_pulse_i,
  input  logic               ext_trig_ni,
  input  logic               sw_trig_i,
  output logic [DATA_W-1:0]  dac0_o,
  output logic [DATA_W-1:0]  dac1_o,
  output logic               req_o,
  output logic               underrun_o
);
  dac_cfg_t          cfg_q;
  logic              upd;
  logic              upd_post;
  logic              ser_acc;
  logic              fifo_acc;
  logic              any_wr;
  logic              fresh_q;
  logic              req_q;
  logic              unr_q;
  logic [NUM_CH-1:0] alt_v;
  logic [NUM_CH-1:0] ch_wr;
  logic [DATA_W-1:0] alt_d  [NUM_CH];
  logic [DATA_W-1:0] ch_dat [NUM_CH];
  logic [DATA_W-1:0] dac_q  [NUM_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{posted: 1'b0, sel: TRG_OFF7, path: PATH_NONE};
    end else if (cfg_we_i) begin
      cfg_q <= '{posted: cfg_posted_i,
                 sel:    trig_sel_e'(cfg_trig_sel_i),
                 path:   path_sel_e'(cfg_path_i)};
    end
  end

  dac_trig_sel #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (cfg_q.sel),
    .ctr_pulse_i (ctr_pulse_i),
    .ext_trig_ni (ext_trig_ni),
    .sw_trig_i   (sw_trig_i),
    .upd_o       (upd)
  );

  assign upd_post = cfg_q.posted & upd;

  // one alternate path at most
  assign ser_acc  = ser_valid_i  && (cfg_q.path == PATH_SER0);
  assign fifo_acc = fifo_valid_i && (cfg_q.path == PATH_FIFO1);

  assign alt_v[0] = ser_acc;
  assign alt_d[0] = ser_data_i;
  assign alt_v[1] = fifo_acc;
  assign alt_d[1] = fifo_data_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic loc_wr;
    assign loc_wr    = wr_en_i && (wr_ch_i == c[0]);
    assign ch_wr[c]  = loc_wr | alt_v[c];
    assign ch_dat[c] = loc_wr ? wr_data_i : alt_d[c];

    dac_chan_buf #(
      .DATA_W(DATA_W)
    ) u_buf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .posted_i (cfg_q.posted),
      .upd_i    (upd),
      .wr_i     (ch_wr[c]),
      .data_i   (ch_dat[c]),
      .out_o    (dac_q[c])
    );
  end

  assign any_wr = |ch_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      unr_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      if (!cfg_q.posted) req_q <= 1'b0;
      else if (upd)      req_q <= 1'b1;
      else if (any_wr)   req_q <= 1'b0;

      if (upd_post && !fresh_q) unr_q <= 1'b1;
      else if (cfg_we_i)        unr_q <= 1'b0;

      if (any_wr)        fresh_q <= 1'b1;
      else if (upd_post) fresh_q <= 1'b0;
    end
  end

  assign dac0_o     = dac_q[0];
  assign dac1_o     = dac_q[1];
  assign req_o      = req_q;
  assign underrun_o = unr_q;

  // R9
  path_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ser_acc && fifo_acc));

  // R6
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(upd_post));

  // R8
  unr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(upd_post) && $stable(dac0_o) && $stable(dac1_o));

  // R7
  direct_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.posted |=> !req_o);
endmodule

// File: tb/dac_post_ctrl_tb.sv
module dac_post_ctrl_tb;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_posted;
  logic [2:0]    cfg_sel;
  logic [1:0]    cfg_path;
  logic          wr_en, wr_ch;
  logic [DW-1:0] wr_data, ser_data, fifo_data;
  logic          ser_valid, fifo_valid;
  logic [3:0]    ctr;
  logic          ext_n, sw;
  logic [DW-1:0] dac0, dac1;
  logic          req, unr;

  always #4 clk = ~clk;

  dac_post_ctrl #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_posted_i(cfg_posted), .cfg_trig_sel_i(cfg_sel), .cfg_path_i(cfg_path),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
    .ser_valid_i(ser_valid), .ser_data_i(ser_data),
    .fifo_valid_i(fifo_valid), .fifo_data_i(fifo_data),
    .ctr_pulse_i(ctr), .ext_trig_ni(ext_n), .sw_trig_i(sw),
    .dac0_o(dac0), .dac1_o(dac1), .req_o(req), .underrun_o(unr)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // reference model state
  logic [DW-1:0] m_out [2];
  logic [DW-1:0] m_buf [2];
  logic          m_req, m_unr, m_fresh, m_posted;
  logic [2:0]    m_sel;
  logic [1:0]    m_path;
  logic          m_e1, m_e2, m_e3;

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("dac0", dac0, m_out[0]);
    chk("dac1", dac1, m_out[1]);
    chk("req", {{(DW-1){1'b0}}, req}, {{(DW-1){1'b0}}, m_req});
    chk("underrun", {{(DW-1){1'b0}}, unr}, {{(DW-1){1'b0}}, m_unr});
  endtask

  task automatic model_reset();
    m_out[0] = '0; m_out[1] = '0; m_buf[0] = '0; m_buf[1] = '0;
    m_req = 0; m_unr = 0; m_fresh = 0; m_posted = 0;
    m_sel = 3'd7; m_path = 2'd0;
    m_e1 = 1; m_e2 = 1; m_e3 = 1;
  endtask

  function automatic logic sel_trig(input logic [2:0] s, input logic [3:0] c,
                                    input logic efall, input logic swv);
    case (s)
      3'd0, 3'd1, 3'd2, 3'd3: return c[s[1:0]];
      3'd4:    return efall;
      3'd5:    return swv;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_tick();
    logic trig, unr_set;
    logic w [2];
    logic [DW-1:0] d [2];
    trig = sel_trig(m_sel, ctr, m_e3 & ~m_e2, sw);
    m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_n;
    w[0] = wr_en && !wr_ch; d[0] = wr_data;
    if (!w[0] && m_path == 2'd1 && ser_valid) begin w[0] = 1; d[0] = ser_data; end
    w[1] = wr_en && wr_ch;  d[1] = wr_data;
    if (!w[1] && m_path == 2'd2 && fifo_valid) begin w[1] = 1; d[1] = fifo_data; end
    unr_set = 0;
    if (m_posted) begin
      if (trig) begin
        m_out[0] = m_buf[0]; m_out[1] = m_buf[1];
        m_req = 1;
        if (!m_fresh) unr_set = 1;
        m_fresh = 0;
      end else if (w[0] || w[1]) m_req = 0;
    end else begin
      m_req = 0;
      if (w[0]) m_out[0] = d[0];
      if (w[1]) m_out[1] = d[1];
    end
    if (w[0]) m_buf[0] = d[0];
    if (w[1]) m_buf[1] = d[1];
    if (w[0] || w[1]) m_fresh = 1;
    if (unr_set) m_unr = 1;
    else if (cfg_we) m_unr = 0;
    if (cfg_we) begin m_posted = cfg_posted; m_sel = cfg_sel; m_path = cfg_path; end
  endtask

  task automatic clear_pulses();
    cfg_we = 0; wr_en = 0; ser_valid = 0; fifo_valid = 0; ctr = '0; sw = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare_all();
    clear_pulses();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg(input logic p, input logic [2:0] s, input logic [1:0] pa);
    cfg_we = 1; cfg_posted = p; cfg_sel = s; cfg_path = pa;
    step();
  endtask

  task automatic hwr(input logic ch, input logic [DW-1:0] v);
    wr_en = 1; wr_ch = ch; wr_data = v;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7319));
    rst_n = 0; ext_n = 1; cfg_posted = 0; cfg_sel = 3'd7; cfg_path = 2'd0;
    wr_ch = 0; wr_data = '0; ser_data = '0; fifo_data = '0;
    clear_pulses();
    model_reset();
    // R1 reset values, with stimulus active during reset
    tag = "R1";
    for (int i = 0; i < 3; i++) begin
      hwr(1'b0, 12'hABC); sw = 1;
      @(negedge clk);
      compare_all();
    end
    clear_pulses();
    @(negedge clk);
    rst_n = 1;
    idle(2);

    // R7 direct mode
    tag = "R7";
    hwr(1'b0, 12'h123); step();
    hwr(1'b1, 12'h456); step();
    cfg(1'b0, 3'd5, 2'd0);
    sw = 1; step();
    hwr(1'b1, 12'h457); sw = 1; step();

    // R2, R5 posted hold and software strobe
    tag = "R2";
    cfg(1'b1, 3'd5, 2'd0);
    hwr(1'b0, 12'h111); step();
    hwr(1'b1, 12'h222); step();
    idle(3);
    tag = "R5";
    sw = 1; step();
    idle(1);

    // R6 request clear and same-edge write plus update
    tag = "R6";
    hwr(1'b0, 12'h333); step();
    hwr(1'b1, 12'h444); sw = 1; step();
    idle(1);
    sw = 1; step();

    // R8 underrun and clear
    tag = "R8";
    sw = 1; step();
    idle(1);
    cfg(1'b1, 3'd5, 2'd0);
    sw = 1; cfg_we = 1; cfg_posted = 1; cfg_sel = 3'd5; cfg_path = 2'd0; step();
    cfg(1'b1, 3'd5, 2'd0);

    // R3 counter selects and disabled codes
    tag = "R3";
    for (int s = 0; s < 4; s++) begin
      cfg(1'b1, 3'(s), 2'd0);
      hwr(1'b0, DW'(12'h500 + s)); step();
      ctr = ~(4'b1 << s); sw = 1; step();
      ctr = 4'b1 << s; step();
    end
    for (int s = 6; s < 8; s++) begin
      cfg(1'b1, 3'(s), 2'd0);
      hwr(1'b1, DW'(12'h600 + s)); step();
      ctr = 4'hF; sw = 1; ext_n = 0; step();
      idle(4);
      ext_n = 1; idle(2);
    end

    // R4 external trigger, held low
    tag = "R4";
    cfg(1'b1, 3'd4, 2'd0);
    hwr(1'b0, 12'h7A1); step();
    ext_n = 0; idle(6);
    hwr(1'b1, 12'h7B2); step();
    idle(3);
    ext_n = 1; idle(3);
    ext_n = 0; step(); ext_n = 1; idle(4);

    // R9 path exclusivity
    tag = "R9";
    for (int p = 0; p < 4; p++) begin
      cfg(1'b1, 3'd5, 2'(p));
      ser_valid = 1; ser_data = DW'(12'h900 + p);
      fifo_valid = 1; fifo_data = DW'(12'hA00 + p); step();
      sw = 1; step();
      idle(1);
    end

    // R10 local write beats path data
    tag = "R10";
    cfg(1'b1, 3'd5, 2'd1);
    hwr(1'b0, 12'hB0B); ser_valid = 1; ser_data = 12'hC0C; step();
    idle(2);
    sw = 1; step();
    cfg(1'b0, 3'd5, 2'd2);
    hwr(1'b1, 12'hD0D); fifo_valid = 1; fifo_data = 12'hE0E; step();

    // random mix
    tag = "RND";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 29) == 0) begin
        cfg_we = 1; cfg_posted = ($urandom_range(0, 3) != 0);
        cfg_sel = 3'($urandom_range(0, 7)); cfg_path = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 3) == 0) hwr(1'($urandom), DW'($urandom));
      ser_valid  = ($urandom_range(0, 4) == 0); ser_data  = DW'($urandom);
      fifo_valid = ($urandom_range(0, 4) == 0); fifo_data = DW'($urandom);
      ctr = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
      sw  = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) ext_n = ~ext_n;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule